// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block turns an idle-high asynchronous serial line into parallel words. While the enable input is high, the receiver looks for a low level on the line. It times each bit with a 16x oversampling enable and assembles one frame per start bit. A frame holds 7 or 8 data bits, sent least significant bit first, then an optional even or odd parity bit, then one stop bit. The baud-rate divider is outside the block and supplies the oversampling enable.

Each finished word is offered on a valid/ready output. `rd_valid` is the data-full flag. A transfer takes place in a cycle where both `rd_valid` and `rd_ready` are high, and that transfer clears the flag. While the consumer holds `rd_ready` low it applies back-pressure, and `rd_data` stays frozen. If a further frame completes during back-pressure, that frame is dropped, the older word is kept and an overrun is flagged. The parity, overrun and framing error flags are sticky. An interrupt request follows the data-full flag when interrupts are enabled.

The start search arms whenever the receiver is enabled, whatever the line level. If the receiver is switched on in the middle of a transmission, it can lock onto a later low data bit and deliver a misaligned word.

Top module: `serial_frame_rx`

## Requirements
- R1: While `rx_en` is 0, no start is searched for and no frame completes. A frame sent while disabled leaves `rd_valid` at 0.
- R2: A bit lasts 16 `os_tick` pulses. A start is detected on a tick that sees the line low. The line is checked again 8 ticks later, and if it is high there, the receiver returns to idle without producing a word.
- R3: Data bits are sampled at mid-bit, least significant first. With `fmt_8bit`=1, 8 bits are received. With `fmt_8bit`=0, 7 bits are received and `rd_data[7]` reads 0.
- R4: With `par_en`=1, a parity bit follows the data. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. A mismatch sets `err_parity`.
- R5: A stop bit sampled low sets `err_framing`. The word is still delivered.
- R6: At the end of every frame, `rd_valid` is 1 on the following cycle, including frames that raised an error flag.
- R7: A cycle with `rd_valid`=1 and `rd_ready`=1 clears `rd_valid`, unless a frame completes in that same cycle. While `rd_valid`=1 and `rd_ready`=0, `rd_data` holds its value.
- R8: A frame that completes while `rd_valid`=1 and no read happens in that cycle sets `err_overrun` and leaves `rd_data` unchanged.
- R9: The error flags stay set until `err_clr` is pulsed or `rx_en` is 0. A completing frame's flags take priority over the clear.
- R10: Lowering `rx_en` in the middle of a frame abandons that frame and leaves `rd_valid` unchanged.
- R11: `irq` is 1 exactly when `irq_en` and `rd_valid` are both 1.
- R12: If the receiver is enabled while the line is high during a data bit, the next low data bit is taken as a start. For example, enabling in the middle of bit 0 of a 0x55 frame with 8 bits and even parity yields 0x95 with `err_parity` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; 0 aborts reception and clears the error flags |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| sin | input | 1 | Serial line, idle high |
| fmt_8bit | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| irq_en | input | 1 | Interrupt enable |
| err_clr | input | 1 | Clears the sticky error flags |
| rd_data | output | DATA_W | Received word |
| rd_valid | output | 1 | Data-full flag |
| rd_ready | input | 1 | Consumer accepts the word |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_framing | output | 1 | Sticky framing error |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches the output handshake on every cycle:
- the data-full flag rises after each accepted frame and never while the receiver is disabled;
- a read clears the flag;
- the word stays stable under back-pressure, and an overrun keeps the older word;
- the clear input or a disable empties the error flags;
- the interrupt never appears without its enable and a full flag.

Several behaviours depend on how the line is shaped over many bit times, and only the bench scenarios can show them:
- mid-bit sampling and the bit order;
- the 7- and 8-bit formats;
- parity in both senses;
- rejection of a short start glitch;
- an abandoned frame;
- the misaligned word produced by enabling in the middle of a frame.

// File: rtl/sfrx_pkg.sv
package sfrx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic parity_bad;
    logic stop_bad;
  } rx_err_t;
endpackage

// File: rtl/sfrx_sync.sv
module sfrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[0] <= 1'b1;
          else        pipe[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[g] <= 1'b1;
          else        pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sfrx_bitctl.sv
module sfrx_bitctl
  import sfrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              line,
  input  logic              fmt_full,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output rx_err_t           errs
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic              perr_q;
  logic [BW-1:0]     last_bit;

  assign last_bit = fmt_full ? BW'(DATA_W - 1) : BW'(DATA_W - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      perr_q  <= 1'b0;
      done    <= 1'b0;
      word    <= '0;
      errs    <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        unique case (state)
          RX_IDLE: begin
            cnt <= '0;
            if (!line) state <= RX_START;
          end
          RX_START: begin
            if (cnt == MID) begin
              cnt     <= '0;
              bitn    <= '0;
              shreg   <= '0;
              par_acc <= 1'b0;
              perr_q  <= 1'b0;
              state   <= line ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == LAST) begin
              cnt     <= '0;
              shreg   <= {line, shreg[DATA_W-1:1]};
              par_acc <= par_acc ^ line;
              if (bitn == last_bit) state <= par_en ? RX_PAR : RX_STOP;
              else                  bitn  <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (cnt == LAST) begin
              cnt    <= '0;
              perr_q <= (par_acc ^ line) != par_odd;
              state  <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == LAST) begin
              cnt             <= '0;
              state           <= RX_IDLE;
              done            <= 1'b1;
              word            <= fmt_full ? shreg : {1'b0, shreg[DATA_W-1:1]};
              errs.parity_bad <= perr_q;
              errs.stop_bad   <= !line;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sfrx_status.sv
module sfrx_status
  import sfrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              done,
  input  logic [DATA_W-1:0] word,
  input  rx_err_t           errs,
  input  logic              rd_ready,
  input  logic              err_clr,
  input  logic              irq_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              err_framing,
  output logic              irq,
  output logic              take
);
  logic rd_fire;

  assign take    = done & en;
  assign rd_fire = rd_valid & rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (take) begin
      rd_valid <= 1'b1;
      if (!rd_valid || rd_fire) rd_data <= word;
    end else if (rd_fire) begin
      rd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
      err_framing <= 1'b0;
    end else if (take) begin
      err_parity  <= err_parity  | errs.parity_bad;
      err_framing <= err_framing | errs.stop_bad;
      err_overrun <= err_overrun | (rd_valid & !rd_fire);
    end else if (err_clr || !en) begin
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
      err_framing <= 1'b0;
    end
  end

  assign irq = irq_en & rd_valid;
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import sfrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              os_tick,
  input  logic              sin,
  input  logic              fmt_8bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              irq_en,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              err_framing,
  output logic              irq
);
  logic              line_s;
  logic              frm_done;
  logic              frm_take;
  logic [DATA_W-1:0] frm_word;
  rx_err_t           frm_errs;

  sfrx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sin),
    .dout (line_s)
  );

  sfrx_bitctl #(.DATA_W(DATA_W), .OVS(OVS)) bitctl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (rx_en),
    .tick    (os_tick),
    .line    (line_s),
    .fmt_full(fmt_8bit),
    .par_en  (par_en),
    .par_odd (par_odd),
    .done    (frm_done),
    .word    (frm_word),
    .errs    (frm_errs)
  );

  sfrx_status #(.DATA_W(DATA_W)) status_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (rx_en),
    .done       (frm_done),
    .word       (frm_word),
    .errs       (frm_errs),
    .rd_ready   (rd_ready),
    .err_clr    (err_clr),
    .irq_en     (irq_en),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .err_parity (err_parity),
    .err_overrun(err_overrun),
    .err_framing(err_framing),
    .irq        (irq),
    .take       (frm_take)
  );
endmodule

// File: rtl/sfrx_checker.sv
module sfrx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              err_clr,
  input logic              irq_en,
  input logic              rd_ready,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              err_parity,
  input logic              err_overrun,
  input logic              err_framing,
  input logic              irq,
  input logic              frm_take
);
  p_disabled_no_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(rd_valid));

  p_full_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_take |=> rd_valid);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !frm_take) |=> !rd_valid);

  p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> $stable(rd_data));

  p_overrun_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_take && rd_valid && !rd_ready) |=> (err_overrun && $stable(rd_data)));

  p_clear_errors_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_clr || !rx_en) && !frm_take) |=> (!err_parity && !err_overrun && !err_framing));

  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && rd_valid));
endmodule

bind serial_frame_rx sfrx_checker #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .err_clr    (err_clr),
  .irq_en     (irq_en),
  .rd_ready   (rd_ready),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .err_parity (err_parity),
  .err_overrun(err_overrun),
  .err_framing(err_framing),
  .irq        (irq),
  .frm_take   (frm_take)
);

// File: tb/serial_frame_rx_tb_top.sv
module serial_frame_rx_tb_top;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       os_tick = 1'b0;
  logic       sin = 1'b1;
  logic       fmt_8bit = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       irq_en = 1'b0;
  logic       err_clr = 1'b0;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, err_parity, err_overrun, err_framing, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [7:0] data;
    logic       f8;
    logic       pen;
    logic       podd;
    logic       pflip;
    logic       stop_ok;
    logic [7:0] exp_data;
    logic       exp_perr;
    logic       exp_ferr;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0},
    '{8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0},
    '{8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0},
    '{8'hFE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h7E, 1'b0, 1'b0},
    '{8'hDA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0},
    '{8'h81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0},
    '{8'h0F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0F, 1'b0, 1'b1},
    '{8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  serial_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .sin(sin),
    .fmt_8bit(fmt_8bit), .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en),
    .err_clr(err_clr), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .err_parity(err_parity), .err_overrun(err_overrun), .err_framing(err_framing),
    .irq(irq)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic b, input int ticks);
    sin = b;
    repeat (ticks * TDIV) @(negedge clk);
  endtask

  // ev: 0 plain, 1 enable in the middle of bit 0, 2 disable at the start of bit 3
  task automatic send_frame(input logic [7:0] d, input logic f8, input logic pen,
                            input logic podd, input logic pflip, input logic stop_ok,
                            input int ev);
    int nb;
    logic p;
    nb = f8 ? 8 : 7;
    p = 1'b0;
    hold_bit(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      p ^= d[i];
      if (ev == 2 && i == 3) rx_en = 1'b0;
      if (ev == 1 && i == 0) begin
        hold_bit(d[i], 8);
        rx_en = 1'b1;
        hold_bit(d[i], 8);
      end else begin
        hold_bit(d[i], 16);
      end
    end
    if (pen) hold_bit(p ^ podd ^ pflip, 16);
    if (stop_ok) hold_bit(1'b1, 16);
    else begin
      hold_bit(1'b0, 10);
      hold_bit(1'b1, 6);
    end
    hold_bit(1'b1, 32);
  endtask

  task automatic do_read();
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clear();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    // Reset state
    check("R6 reset valid", rd_valid, 0);
    check("R9 reset flags", {err_parity, err_overrun, err_framing}, 0);
    check("R11 reset irq", irq, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: disabled receiver ignores a full frame
    send_frame(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    check("R1 no word while disabled", rd_valid, 0);
    rx_en = 1'b1;
    hold_bit(1'b1, 16);

    // Table-driven formats: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < 8; k++) begin
      fmt_8bit = VEC[k].f8;
      par_en   = VEC[k].pen;
      par_odd  = VEC[k].podd;
      send_frame(VEC[k].data, VEC[k].f8, VEC[k].pen, VEC[k].podd,
                 VEC[k].pflip, VEC[k].stop_ok, 0);
      check("R6 full after frame", rd_valid, 1);
      check("R3 data", rd_data, VEC[k].exp_data);
      check("R4 parity flag", err_parity, VEC[k].exp_perr);
      check("R5 framing flag", err_framing, VEC[k].exp_ferr);
      do_read();
      check("R7 read clears full", rd_valid, 0);
      do_clear();
      check("R9 clear strobe", {err_parity, err_framing}, 0);
    end

    // R11 interrupt follows full flag and enable
    fmt_8bit = 1'b1; par_en = 1'b0; par_odd = 1'b0;
    irq_en = 1'b1;
    check("R11 irq idle", irq, 0);
    send_frame(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    check("R11 irq raised", irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    check("R11 irq masked", irq, 0);
    check("R11 full kept", rd_valid, 1);
    do_read();

    // R8 overrun, R7 data held under back-pressure
    send_frame(8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    send_frame(8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    check("R8 overrun flag", err_overrun, 1);
    check("R8 older data kept", rd_data, 8'h11);
    check("R7 full held", rd_valid, 1);
    do_read();
    check("R7 read after overrun", rd_valid, 0);
    check("R9 overrun sticky", err_overrun, 1);
    do_clear();
    check("R9 overrun cleared", err_overrun, 0);

    // R9 disable clears flags
    par_en = 1'b1;
    send_frame(8'h81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 0);
    check("R4 parity error", err_parity, 1);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 disable clears", err_parity, 0);
    do_read();
    rx_en = 1'b1;
    par_en = 1'b0;
    hold_bit(1'b1, 16);

    // R2 start glitch rejected
    hold_bit(1'b0, 4);
    hold_bit(1'b1, 40);
    check("R2 glitch no word", rd_valid, 0);
    check("R2 glitch no flags", {err_parity, err_overrun, err_framing}, 0);
    send_frame(8'h96, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    check("R2 frame after glitch", rd_data, 8'h96);
    do_read();

    // R10 abort mid-frame
    send_frame(8'h3F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2);
    check("R10 aborted no word", rd_valid, 0);
    rx_en = 1'b1;
    hold_bit(1'b1, 16);
    send_frame(8'h66, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    check("R10 recovers valid", rd_valid, 1);
    check("R10 recovers data", rd_data, 8'h66);
    do_read();

    // R12 enabling mid-frame misaligns
    rx_en = 1'b0;
    fmt_8bit = 1'b1; par_en = 1'b1; par_odd = 1'b0;
    repeat (2) @(negedge clk);
    send_frame(8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1);
    check("R12 misaligned valid", rd_valid, 1);
    check("R12 misaligned data", rd_data, 8'h95);
    check("R12 parity flagged", err_parity, 1);
    check("R12 no framing", err_framing, 0);
    do_read();

    summary();
  end
endmodule